// File: doc/BRIEF.md
# Beam Position Capture and Byte Readout

This block freezes the horizontal and vertical beam counters of a video timing chain into two holding registers, then hands them out over an 8-bit read bus. The counters are 9-bit inputs and keep running; the held copies change only when a sticky capture flag rises from clear to set. Two sources can set the flag. One is a read strobe on a software capture address, which returns the open-bus byte. The other is an external active-low capture pin, which passes through a two-flop synchroniser and acts as a level.

Each held value is read as two bytes over two successive reads, low byte first, through a byte toggle kept per axis. In the high byte only bit 0 carries counter data; the other bits come from the supplied open-bus byte. A read of the status byte reports the capture flag together with the interlace field, the video standard and a version nibble. The same read clears the flag and returns both byte toggles to the low byte.

The flag is held in a two-state machine. The state FLAG_CLEAR moves to FLAG_SET on the *arm* transition, which fires whenever a set source is active, and the holding registers load on that transition. FLAG_SET moves back to FLAG_CLEAR on the *release* transition: a status read while no set source is active. In every other case the machine takes the *hold* transition and keeps its state.

Top module: `beampos_capture`

## Requirements
- R1: A software capture strobe sets the flag, and while it is the only strobe active, rd_data_o equals openbus_i.
- R2: While ext_latch_n_i is low, the flag is set. The first capture uses the counter values present at the third rising edge after the pin is first sampled low, counting that sampling edge as the first.
- R3: On the arm transition (flag 0 to 1), both holding registers load hpos_i and vpos_i as sampled at that edge.
- R4: While the flag stays set, the holding registers keep their values whatever the counters and further set sources do.
- R5: Successive reads of one axis alternate between the low byte (held bits 7:0) and the high byte ({openbus_i[7:1], held bit 8}). The first read after reset or after a status read returns the low byte. The two axes toggle independently.
- R6: A status read returns {field_i, flag, openbus_i[5], pal_i, VERSION[3:0]}, with bit 7 first. The flag shown is the value before the read.
- R7: A status read with no set source active clears the flag. A set source that is active at a later edge then arms again and recaptures.
- R8: A status read in the same cycle as an active set source leaves the flag set and does not recapture.
- R9: A status read returns both byte toggles to the low byte.
- R10: After reset the flag is 0, both toggles select the low byte, and both holding registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos_i | input | 9 | Running horizontal beam counter |
| vpos_i | input | 9 | Running vertical beam counter |
| ext_latch_n_i | input | 1 | Asynchronous active-low capture pin |
| soft_latch_rd_i | input | 1 | Read strobe of the software capture address |
| hcnt_rd_i | input | 1 | Read strobe of the horizontal held value |
| vcnt_rd_i | input | 1 | Read strobe of the vertical held value |
| status_rd_i | input | 1 | Read strobe of the status byte |
| field_i | input | 1 | Current interlace field |
| pal_i | input | 1 | Video standard, 1 = 50 Hz |
| openbus_i | input | 8 | Open-bus byte for undriven bits |
| rd_data_o | output | 8 | Read data for the strobe active in this cycle |

## Verification
A status read can fall in the same cycle as an active set source, and the clear and the set then compete for the flag. The bench provokes this by holding the external pin low across a status read after a capture, and it changes the counters beforehand. It then checks that a second status read still shows the flag set and that the held horizontal value keeps its old capture. It also checks the reverse case: once the pin is released, a status read clears the flag and a later software strobe captures fresh counter values.

// File: rtl/beampos_pkg.sv
package beampos_pkg;

    typedef enum logic [0:0] {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_t;

    typedef enum logic [1:0] {
        SEL_OPEN   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_HORZ   = 2'd2,
        SEL_VERT   = 2'd3
    } rd_sel_t;

    localparam int AXES = 2;
    localparam int AXIS_H = 0;
    localparam int AXIS_V = 1;

endpackage

// File: rtl/beampos_sync.sv
module beampos_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/beampos_flag_fsm.sv
module beampos_flag_fsm
    import beampos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o,
    output logic capture_o
);
    flag_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, release, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i)                 state_d = FLAG_SET;
            FLAG_SET:   if (clear_i && !set_i)     state_d = FLAG_CLEAR;
            default:                               state_d = FLAG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag_o    = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            FLAG_CLEAR: capture_o = set_i;
            FLAG_SET:   flag_o    = 1'b1;
            default:    flag_o    = 1'b0;
        endcase
    end
endmodule

// File: rtl/beampos_byte_port.sv
module beampos_byte_port #(
    parameter int CNT_W = 9,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             rd_i,
    input  logic             toggle_clr_i,
    input  logic [BUS_W-1:0] openbus_i,
    output logic [BUS_W-1:0] byte_o,
    output logic [CNT_W-1:0] held_o,
    output logic             toggle_o
);
    localparam int HI_W = CNT_W - BUS_W;

    logic [CNT_W-1:0] held_q;
    logic             tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (capture_i) begin
            held_q <= count_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (toggle_clr_i) begin
            tog_q <= 1'b0;
        end else if (rd_i) begin
            tog_q <= ~tog_q;
        end
    end

    always_comb begin
        if (tog_q) begin
            byte_o = {openbus_i[BUS_W-1:HI_W], held_q[CNT_W-1:BUS_W]};
        end else begin
            byte_o = held_q[BUS_W-1:0];
        end
    end

    assign held_o   = held_q;
    assign toggle_o = tog_q;
endmodule

// File: rtl/beampos_capture.sv
module beampos_capture
    import beampos_pkg::*;
#(
    parameter int         CNT_W   = 9,
    parameter int         BUS_W   = 8,
    parameter logic [3:0] VERSION = 4'h3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hpos_i,
    input  logic [CNT_W-1:0] vpos_i,
    input  logic             ext_latch_n_i,
    input  logic             soft_latch_rd_i,
    input  logic             hcnt_rd_i,
    input  logic             vcnt_rd_i,
    input  logic             status_rd_i,
    input  logic             field_i,
    input  logic             pal_i,
    input  logic [BUS_W-1:0] openbus_i,
    output logic [BUS_W-1:0] rd_data_o
);
    logic             ext_sync_n;
    logic             set_w;
    logic             flag_w;
    logic             capture_w;
    logic [CNT_W-1:0] count_w [AXES];
    logic             rd_w    [AXES];
    logic [BUS_W-1:0] byte_w  [AXES];
    logic [CNT_W-1:0] held_w  [AXES];
    logic             tog_w   [AXES];
    logic [BUS_W-1:0] status_byte;
    rd_sel_t          sel;

    beampos_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_latch_n_i),
        .sync_o  (ext_sync_n)
    );

    assign set_w = soft_latch_rd_i | ~ext_sync_n;

    beampos_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_w),
        .clear_i   (status_rd_i),
        .flag_o    (flag_w),
        .capture_o (capture_w)
    );

    assign count_w[AXIS_H] = hpos_i;
    assign count_w[AXIS_V] = vpos_i;
    assign rd_w[AXIS_H]    = hcnt_rd_i;
    assign rd_w[AXIS_V]    = vcnt_rd_i;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        beampos_byte_port #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .capture_i    (capture_w),
            .count_i      (count_w[g]),
            .rd_i         (rd_w[g]),
            .toggle_clr_i (status_rd_i),
            .openbus_i    (openbus_i),
            .byte_o       (byte_w[g]),
            .held_o       (held_w[g]),
            .toggle_o     (tog_w[g])
        );
    end

    assign status_byte = {field_i, flag_w, openbus_i[5], pal_i, VERSION};

    always_comb begin
        if (status_rd_i)    sel = SEL_STATUS;
        else if (hcnt_rd_i) sel = SEL_HORZ;
        else if (vcnt_rd_i) sel = SEL_VERT;
        else                sel = SEL_OPEN;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_data_o = status_byte;
            SEL_HORZ:   rd_data_o = byte_w[AXIS_H];
            SEL_VERT:   rd_data_o = byte_w[AXIS_V];
            default:    rd_data_o = openbus_i;
        endcase
    end
endmodule

// File: rtl/beampos_capture_chk.sv
module beampos_capture_chk #(
    parameter int CNT_W = 9,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] hpos_i,
    input logic [CNT_W-1:0] vpos_i,
    input logic             soft_latch_rd_i,
    input logic             hcnt_rd_i,
    input logic             vcnt_rd_i,
    input logic             status_rd_i,
    input logic [BUS_W-1:0] openbus_i,
    input logic [BUS_W-1:0] rd_data_o,
    input logic             set_w,
    input logic             flag_w,
    input logic [CNT_W-1:0] held_h,
    input logic [CNT_W-1:0] held_v,
    input logic             tog_h,
    input logic             tog_v
);
    a_r1_soft_returns_openbus: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_latch_rd_i && !status_rd_i && !hcnt_rd_i && !vcnt_rd_i) |-> (rd_data_o == openbus_i));

    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_latch_rd_i, hcnt_rd_i, vcnt_rd_i, status_rd_i}));

    a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_w) |-> (held_h == $past(hpos_i) && held_v == $past(vpos_i)));

    a_r4_hold_while_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_w && $past(flag_w)) |-> ($stable(held_h) && $stable(held_v)));

    a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && !set_w) |=> !flag_w);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> flag_w);

    a_r9_toggles_reset: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd_i |=> (!tog_h && !tog_v));
endmodule

bind beampos_capture beampos_capture_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .hpos_i          (hpos_i),
    .vpos_i          (vpos_i),
    .soft_latch_rd_i (soft_latch_rd_i),
    .hcnt_rd_i       (hcnt_rd_i),
    .vcnt_rd_i       (vcnt_rd_i),
    .status_rd_i     (status_rd_i),
    .openbus_i       (openbus_i),
    .rd_data_o       (rd_data_o),
    .set_w           (set_w),
    .flag_w          (flag_w),
    .held_h          (held_w[0]),
    .held_v          (held_w[1]),
    .tog_h           (tog_w[0]),
    .tog_v           (tog_w[1])
);

// File: tb/beampos_capture_tb_top.sv
module beampos_capture_tb_top;
    localparam logic [3:0] VER = 4'h3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] hpos = '0;
    logic [8:0] vpos = '0;
    logic       ext_n = 1'b1;
    logic       soft_rd = 1'b0;
    logic       h_rd = 1'b0;
    logic       v_rd = 1'b0;
    logic       st_rd = 1'b0;
    logic       field = 1'b0;
    logic       pal = 1'b0;
    logic [7:0] ob = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    beampos_capture dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .hpos_i          (hpos),
        .vpos_i          (vpos),
        .ext_latch_n_i   (ext_n),
        .soft_latch_rd_i (soft_rd),
        .hcnt_rd_i       (h_rd),
        .vcnt_rd_i       (v_rd),
        .status_rd_i     (st_rd),
        .field_i         (field),
        .pal_i           (pal),
        .openbus_i       (ob),
        .rd_data_o       (rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, got, exp);
        end
    endtask

    // kind: 0 soft, 1 horizontal, 2 vertical, 3 status
    task automatic rd(input int kind, output logic [7:0] d);
        @(negedge clk);
        case (kind)
            0: soft_rd = 1'b1;
            1: h_rd    = 1'b1;
            2: v_rd    = 1'b1;
            default: st_rd = 1'b1;
        endcase
        #1 d = rdata;
        @(posedge clk);
        #1;
        soft_rd = 1'b0; h_rd = 1'b0; v_rd = 1'b0; st_rd = 1'b0;
    endtask

    function automatic logic [7:0] st_exp(input logic flag);
        return {field, flag, ob[5], pal, VER};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        field = 1'b1; pal = 1'b0; ob = 8'h20;
        rd(3, d); check("R10 flag clear / R6 layout", d, st_exp(1'b0));
        rd(1, d); check("R10 held horizontal zero", d, 8'h00);
        rd(1, d); check("R10 high byte", d, {ob[7:1], 1'b0});
        rd(3, d);
    endtask

    task automatic t_soft_capture();
        logic [7:0] d;
        ob = 8'hC6; hpos = 9'h1A5; vpos = 9'h0F3;
        rd(0, d); check("R1 soft read returns open bus", d, 8'hC6);
        hpos = 9'h011; vpos = 9'h122;
        rd(1, d); check("R3/R5 h low", d, 8'hA5);
        rd(1, d); check("R5 h high", d, {ob[7:1], 1'b1});
        rd(2, d); check("R3/R5 v low", d, 8'hF3);
        rd(2, d); check("R5 v high", d, {ob[7:1], 1'b0});
        rd(1, d); check("R5 h wraps to low", d, 8'hA5);
    endtask

    task automatic t_hold_and_clear();
        logic [7:0] d;
        hpos = 9'h0EE; vpos = 9'h1DD;
        rd(0, d);
        rd(3, d); check("R6 flag shown set / R4", d, st_exp(1'b1));
        rd(1, d); check("R4 no recapture while set", d, 8'hA5);
        rd(3, d); check("R7 status cleared flag", d, st_exp(1'b0));
    endtask

    task automatic t_toggle_reset();
        logic [7:0] d;
        rd(2, d); check("R5 v low before reset", d, 8'hF3);
        rd(3, d);
        rd(2, d); check("R9 toggle back to low", d, 8'hF3);
        rd(1, d);
        rd(3, d);
        rd(1, d); check("R9 h toggle back to low", d, 8'hA5);
    endtask

    task automatic t_ext_capture();
        logic [7:0] d;
        pal = 1'b1; field = 1'b0;
        hpos = 9'h133; vpos = 9'h044;
        @(negedge clk); ext_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_n = 1'b1;
        repeat (3) @(negedge clk);
        hpos = 9'h000;
        rd(3, d); check("R2 external set flag", d, st_exp(1'b1));
        rd(1, d); check("R2 external captured h low", d, 8'h33);
        rd(1, d); check("R2 external captured h high", d, {ob[7:1], 1'b1});
        rd(2, d); check("R2 external captured v low", d, 8'h44);
        rd(3, d);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        hpos = 9'h0AB; vpos = 9'h0CD;
        @(negedge clk); ext_n = 1'b0;
        repeat (4) @(negedge clk);
        hpos = 9'h1FF; vpos = 9'h100;
        rd(3, d); check("R8 flag set at collision", d, st_exp(1'b1));
        rd(3, d); check("R8 flag kept set", d, st_exp(1'b1));
        rd(1, d); check("R8 no relatch", d, 8'hAB);
        ext_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(3, d); check("R7 flag still set before clear", d, st_exp(1'b1));
        rd(3, d); check("R7 cleared after release", d, st_exp(1'b0));
        hpos = 9'h155;
        rd(0, d);
        rd(1, d); check("R7 relatch after clear", d, 8'h55);
        rd(3, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_soft_capture();
        t_hold_and_clear();
        t_toggle_reset();
        t_ext_capture();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule